// File: doc/BRIEF.md
# Configuration Register Unit for a Double-Rate Memory Command Bus

This block watches a memory command bus that is sampled on the rising clock edge and captures the two configuration registers a double-data-rate memory device keeps: a base register and an extended register. A register write is the command in which chip select, row strobe, column strobe and write enable are all low. It is only recognised when clock enable was high on both the previous and the current sampling edge. The two bank bits pick the target register. The address bus carries the field codes.

The base register holds the read latency, the burst length and the burst ordering. The extended register holds the refresh area used during partial-array self refresh and the output drive strength. The unit decodes these fields into ready-to-use values for the rest of the controller.

The unit also polices the writes. Any of the following is refused with a one-cycle error pulse, and the stored settings stay as they were:
- a write that uses a reserved code;
- a write that sets an address bit no field uses;
- a write that targets an undefined bank code;
- a write issued while a bank is open;
- a write issued during the two-cycle recovery window that follows every accepted write.

An accepted base write also puts the extended register back to its defaults.

Top module: `modereg_unit`

## Requirements
- R1: A register write is recognised only when cs_n, ras_n, cas_n and we_n are all low at a rising edge and cke was high at that edge and the edge before. Any other combination changes no output and raises no error.
- R2: An accepted base write (bank_sel = 2'b00) updates cas_lat, burst_len and burst_ilv in the cycle after the command. It also sets base_valid, which then stays high until reset.
- R3: The base burst length code sits in addr[2:0]: 001 gives burst_len 2, 010 gives 4, 011 gives 8 and 100 gives 16. Every other code is reserved.
- R4: addr[3] of a base write sets the burst ordering (0 sequential, 1 interleaved), shown on burst_ilv. addr[6:4] gives the read latency: 010 gives cas_lat 2 and 011 gives 3. Every other code is reserved.
- R5: An accepted extended write (bank_sel = 2'b10) takes the refresh area from addr[2:0] and the drive strength from addr[6:5]. For the refresh area, 000 means full array, 001 half and 010 quarter, shown on refresh_area as 0, 1 and 2; other codes are reserved. For the drive strength, 00 means full, 01 half, 10 quarter and 11 eighth, shown unchanged on drive_str.
- R6: After reset, base_valid, busy and err are 0, refresh_area is 0 (full array) and drive_str is 01 (half strength).
- R7: Every accepted base write returns refresh_area to 0 and drive_str to 01 in the same cycle as the base fields update.
- R8: An accepted write drives busy high in the two cycles after the command. busy is low again in the third cycle.
- R9: A write sampled while busy is high is refused. err is high in the next cycle, no setting changes, and the busy window is not extended.
- R10: A write sampled while banks_idle is low is refused with an err pulse and changes no setting.
- R11: A write with a reserved code, with any of addr[12:7] set, or (extended only) with addr[4:3] nonzero is refused with an err pulse and changes no setting.
- R12: A write with bank_sel 2'b01 or 2'b11 is refused with an err pulse and changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable of the command bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 2 | Bank bits, pick the target register |
| addr | input | 13 | Address bus carrying the field codes |
| banks_idle | input | 1 | High when every bank is precharged |
| base_valid | output | 1 | Base register has been written since reset |
| cas_lat | output | 3 | Read latency in cycles |
| burst_len | output | 5 | Burst length in beats |
| burst_ilv | output | 1 | 1 for interleaved ordering, 0 for sequential |
| refresh_area | output | 2 | 0 full, 1 half, 2 quarter array |
| drive_str | output | 2 | 00 full, 01 half, 10 quarter, 11 eighth strength |
| busy | output | 1 | Recovery window after an accepted write |
| err | output | 1 | One-cycle pulse for a refused write |

## Verification
A wrong decode of a field code shows up on the decoded outputs in the first cycle after the write. The bench compares every output there, so a swapped length or latency entry is caught on the write that uses it. A wrong legality decision shows in the same cycle in two ways: err is set or missing, and the fields change or hold contrary to expectation. A miscounted recovery window shows as busy with the wrong value one or two cycles later, or as a follow-up write that is accepted or refused against prediction.

// File: rtl/modereg_pkg.sv
package modereg_pkg;
  // address bit positions of the fields (decoded by the controller side)
  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int DS_LSB  = 5;
  localparam int RSV_LSB = 7;

  localparam logic [1:0] SEL_BASE   = 2'b00;
  localparam logic [1:0] SEL_EXT    = 2'b10;
  localparam logic [1:0] DS_DEFAULT = 2'b01;
  localparam logic [1:0] AREA_FULL  = 2'b00;

  function automatic logic bl_code_ok(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  function automatic logic [4:0] bl_value(input logic [2:0] c);
    return 5'd1 << c;
  endfunction

  function automatic logic cl_code_ok(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3);
  endfunction

  function automatic logic area_code_ok(input logic [2:0] c);
    return c <= 3'd2;
  endfunction
endpackage

// File: rtl/modereg_decode.sv
module modereg_decode
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              cke_now,
  input  logic              cke_prev,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        bank_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              busy,
  output logic              wr_cmd,
  output logic              accept_base,
  output logic              accept_ext,
  output logic              reject
);
  logic hit_base, hit_ext, rsv_clear, base_ok, ext_ok, gate_ok;

  always_comb begin
    wr_cmd    = cke_prev & cke_now & ~cs_n & ~ras_n & ~cas_n & ~we_n;
    hit_base  = (bank_sel == SEL_BASE);
    hit_ext   = (bank_sel == SEL_EXT);
    rsv_clear = (addr[ADDR_W-1:RSV_LSB] == '0);
    base_ok   = rsv_clear && bl_code_ok(addr[BL_LSB+2:BL_LSB])
                && cl_code_ok(addr[CL_LSB+2:CL_LSB]);
    ext_ok    = rsv_clear && (addr[CL_LSB:BT_BIT] == 2'b00)
                && area_code_ok(addr[2:0]);
    gate_ok   = banks_idle & ~busy;
    accept_base = wr_cmd & gate_ok & hit_base & base_ok;
    accept_ext  = wr_cmd & gate_ok & hit_ext & ext_ok;
    reject      = wr_cmd & ~(accept_base | accept_ext);
  end
endmodule

// File: rtl/modereg_busy.sv
module modereg_busy #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  a_r8_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  a_r8_window_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt == CW'(1)) |=> !busy);
endmodule

// File: rtl/modereg_regs.sv
module modereg_regs
  import modereg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_base,
  input  logic       accept_ext,
  input  logic [2:0] bl_code,
  input  logic       bt_bit,
  input  logic [2:0] cl_code,
  input  logic [1:0] area_code,
  input  logic [1:0] ds_code,
  output logic       base_valid,
  output logic [2:0] cas_lat,
  output logic [4:0] burst_len,
  output logic       burst_ilv,
  output logic [1:0] refresh_area,
  output logic [1:0] drive_str
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_valid <= 1'b0;
      cas_lat    <= '0;
      burst_len  <= '0;
      burst_ilv  <= 1'b0;
    end else if (accept_base) begin
      base_valid <= 1'b1;
      cas_lat    <= cl_code;
      burst_len  <= bl_value(bl_code);
      burst_ilv  <= bt_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept_base) begin
      refresh_area <= AREA_FULL;
      drive_str    <= DS_DEFAULT;
    end else if (accept_ext) begin
      refresh_area <= area_code;
      drive_str    <= ds_code;
    end
  end

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    base_valid |=> base_valid);
  a_r7_ext_default: assert property (@(posedge clk) disable iff (!rst_n)
    accept_base |=> (drive_str == 2'b01 && refresh_area == 2'b00));
endmodule

// File: rtl/modereg_unit.sv
module modereg_unit
  import modereg_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BUSY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        bank_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic              base_valid,
  output logic [2:0]        cas_lat,
  output logic [4:0]        burst_len,
  output logic              burst_ilv,
  output logic [1:0]        refresh_area,
  output logic [1:0]        drive_str,
  output logic              busy,
  output logic              err
);
  logic cke_prev;
  logic wr_cmd, accept_base, accept_ext, reject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_prev <= 1'b0;
      err      <= 1'b0;
    end else begin
      cke_prev <= cke;
      err      <= reject;
    end
  end

  modereg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cke_now(cke), .cke_prev(cke_prev), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
    .banks_idle(banks_idle), .busy(busy), .wr_cmd(wr_cmd),
    .accept_base(accept_base), .accept_ext(accept_ext), .reject(reject)
  );

  modereg_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(accept_base | accept_ext), .busy(busy)
  );

  modereg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .accept_base(accept_base), .accept_ext(accept_ext),
    .bl_code(addr[BL_LSB+2:BL_LSB]), .bt_bit(addr[BT_BIT]),
    .cl_code(addr[CL_LSB+2:CL_LSB]), .area_code(addr[1:0]),
    .ds_code(addr[DS_LSB+1:DS_LSB]), .base_valid(base_valid), .cas_lat(cas_lat),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .refresh_area(refresh_area),
    .drive_str(drive_str)
  );

  a_r1_err_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_cmd));
  a_r9_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> err);
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_base || accept_ext) |-> !busy);
  a_r10_open_bank_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !banks_idle) |=> err);
  a_r12_bad_bank_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && bank_sel[0]) |=> err);
  a_r11_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(cas_lat) && $stable(burst_len) && $stable(burst_ilv)
             && $stable(refresh_area) && $stable(drive_str) && $stable(base_valid)));
endmodule

// File: tb/modereg_unit_test.sv
module modereg_unit_test;
  logic clk = 1'b0;
  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, banks_idle;
  logic [1:0] bank_sel;
  logic [12:0] addr;
  logic base_valid, burst_ilv, busy, err;
  logic [2:0] cas_lat;
  logic [4:0] burst_len;
  logic [1:0] refresh_area, drive_str;

  always #10 clk = ~clk;

  modereg_unit uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .addr(addr),
    .banks_idle(banks_idle), .base_valid(base_valid), .cas_lat(cas_lat),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .refresh_area(refresh_area),
    .drive_str(drive_str), .busy(busy), .err(err)
  );

  typedef struct packed {
    logic [31:0] due;
    logic        err;
    logic        valid;
    logic [2:0]  cl;
    logic [4:0]  bl;
    logic        bt;
    logic [1:0]  area;
    logic [1:0]  ds;
    logic        busy;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic last_cke = 1'b0;

  // reference state
  logic       m_valid = 0, m_bt = 0;
  logic [2:0] m_cl = 0;
  logic [4:0] m_bl = 0;
  logic [1:0] m_area = 2'd0, m_ds = 2'd1;
  int         busy_end = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic issue(input logic k, input logic c, input logic r, input logic a,
                       input logic w, input logic [1:0] ba, input logic [12:0] ad,
                       input logic idle_in, input string tag);
    exp_t e;
    bit seen, bad;
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w;
    bank_sel = ba; addr = ad; banks_idle = idle_in;
    seen = last_cke && k && !c && !r && !a && !w;
    bad = 0;
    if (seen) begin
      if (cyc < busy_end || !idle_in || ad[12:7] != 6'd0) bad = 1;
      if (ba == 2'b00) begin
        if (!(ad[2:0] inside {3'd1, 3'd2, 3'd3, 3'd4})) bad = 1;
        if (!(ad[6:4] inside {3'd2, 3'd3})) bad = 1;
      end else if (ba == 2'b10) begin
        if (ad[4:3] != 2'd0 || ad[2:0] > 3'd2) bad = 1;
      end else bad = 1;
      if (!bad) begin
        busy_end = cyc + 3;
        if (ba == 2'b00) begin
          m_valid = 1; m_bt = ad[3]; m_cl = ad[6:4];
          case (ad[2:0])
            3'd1: m_bl = 5'd2;
            3'd2: m_bl = 5'd4;
            3'd3: m_bl = 5'd8;
            default: m_bl = 5'd16;
          endcase
          m_area = 2'd0; m_ds = 2'd1;
        end else begin
          m_area = ad[1:0]; m_ds = ad[6:5];
        end
      end
    end
    e.due = 32'(cyc + 1); e.err = seen && bad; e.valid = m_valid; e.cl = m_cl;
    e.bl = m_bl; e.bt = m_bt; e.area = m_area; e.ds = m_ds;
    e.busy = (cyc + 1 < busy_end);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_cke = k;
  endtask

  task automatic wr(input logic [1:0] ba, input logic [12:0] ad, input string tag);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ba, ad, 1'b1, tag);
  endtask

  task automatic nop(input int n, input logic k);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cke = k; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
      banks_idle = 1'b1; last_cke = k;
    end
  endtask

  // monitor: compares outputs in the cycle after each command
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && exp_q[0].due == 32'(cyc)) begin
        exp_t e;
        exp_t act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = e;
        act.err = err; act.valid = base_valid; act.cl = cas_lat; act.bl = burst_len;
        act.bt = burst_ilv; act.area = refresh_area; act.ds = drive_str; act.busy = busy;
        checks++;
        if (act != e) begin
          errors++;
          $display("FAIL %s: actual err=%0b valid=%0b cl=%0d bl=%0d ilv=%0b area=%0d ds=%0d busy=%0b expected err=%0b valid=%0b cl=%0d bl=%0d ilv=%0b area=%0d ds=%0d busy=%0b",
                   t, act.err, act.valid, act.cl, act.bl, act.bt, act.area, act.ds, act.busy,
                   e.err, e.valid, e.cl, e.bl, e.bt, e.area, e.ds, e.busy);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    bank_sel = 2'b00; addr = '0; banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    checks++;
    if (base_valid !== 1'b0 || busy !== 1'b0 || err !== 1'b0 ||
        refresh_area !== 2'd0 || drive_str !== 2'd1) begin
      errors++;
      $display("FAIL R6 reset: actual valid=%0b busy=%0b err=%0b area=%0d ds=%0d expected 0 0 0 0 1",
               base_valid, busy, err, refresh_area, drive_str);
    end
    nop(1, 1'b0);
    wr(2'b00, 13'h032, "R1 cke low before command ignored");
    issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 13'h032, 1'b1, "R1 chip select high ignored");
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 13'h032, 1'b1, "R1 cke low now ignored");
    issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 13'h032, 1'b1, "R1 cas high not a register write");
    nop(2, 1'b1);
    wr(2'b00, 13'h032, "R2 R3 R4 base bl4 seq cl3");
    wr(2'b10, 13'h061, "R9 ext during busy cycle 1");
    wr(2'b10, 13'h061, "R9 ext during busy cycle 2");
    wr(2'b10, 13'h061, "R5 R8 ext half area eighth drive after window");
    nop(3, 1'b1);
    wr(2'b00, 13'h02C, "R7 R3 R4 base bl16 interleave cl2 resets ext");
    nop(3, 1'b1);
    wr(2'b10, 13'h042, "R5 ext quarter area quarter drive");
    nop(3, 1'b1);
    wr(2'b00, 13'h031, "R3 base bl2 cl3");
    nop(3, 1'b1);
    wr(2'b00, 13'h02B, "R3 R4 base bl8 interleave cl2");
    nop(3, 1'b1);
    wr(2'b10, 13'h000, "R5 ext full area full drive");
    nop(3, 1'b1);
    wr(2'b00, 13'h030, "R11 base burst code 000 reserved");
    wr(2'b00, 13'h035, "R11 base burst code 101 reserved");
    wr(2'b00, 13'h042, "R11 base latency code 100 reserved");
    wr(2'b00, 13'h012, "R11 base latency code 001 reserved");
    wr(2'b00, 13'h0B2, "R11 base addr7 set");
    wr(2'b10, 13'h003, "R11 ext area code 011 reserved");
    wr(2'b10, 13'h008, "R11 ext addr3 set");
    wr(2'b10, 13'h1000, "R11 ext addr12 set");
    wr(2'b01, 13'h032, "R12 bank 01 rejected");
    wr(2'b11, 13'h001, "R12 bank 11 rejected");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 13'h031, 1'b0, "R10 base with open bank");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 13'h021, 1'b0, "R10 ext with open bank");
    wr(2'b10, 13'h021, "R5 ext half area half drive after rejects");
    nop(1, 1'b1);
    wr(2'b10, 13'h000, "R9 second cycle of busy window");
    wr(2'b10, 13'h000, "R8 accepted on third cycle");
    nop(5, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule